// File: doc/BRIEF.md
# Windowed Down-Counting Watchdog Timer

This block is a watchdog that counts down from a selectable period and expects software to refresh it, but only inside the parts of the period that software has allowed. The period is split into four equal quarters. A 4-bit mask names the quarters in which a refresh is legal. Any combination of quarters may be chosen, including non-adjacent ones such as the first and third. A refresh outside every allowed quarter is an error. So is letting the count run past zero. Either error can raise an interrupt level or a single-cycle reset request.

The counter decrements once per prescaler tick. The prescaler ratio comes from a fixed set of divisions of the clock. A refresh is a two-write key sequence on a small register port. The same port carries configuration, the live 16-bit count, and two sticky status flags that are cleared by writing 1. A low-power input can freeze counting when configuration asks for it.

Top module: `win_wdt`

## Requirements
- R1: While and after reset, the status word reads count 255 with both flags clear. The configuration word reads 0x0000_0F00: 256-count period, divide by 1, all four quarters allowed, no freeze, interrupt response. irq_o and rst_req_o are low.
- R2: CFG[1:0] selects the period: 0 gives 256, 1 gives 4096, 2 gives 16384 and 3 gives 65536 counts. The counter reloads to period-1.
- R3: CFG[7:4] selects the prescaler: code 4 divides by 16, 5 by 32, 6 by 64, 7 by 128, 8 by 256 and 11 by 2048. Code 0 and every unlisted code divide by 1. A tick comes on the last clock of each division.
- R4: Each tick decrements the count by one. A tick at count 0 sets the sticky underflow flag and reloads period-1, and counting continues.
- R5: With CFG[12]=1, the count and the prescaler hold while lp_i is high. With CFG[12]=0, lp_i is ignored.
- R6: A refresh checks the elapsed ticks since the last reload, which is period-1-count. Elapsed ticks below period/4 fall in quarter 0, and so on. CFG[11:8] bit q allows a refresh in quarter q. Mask 0 makes every refresh an error.
- R7: A refresh happens only when a write of 16'h3210 to KEY (address 1) directly follows a write of 16'h0123 to KEY. Any other write in between cancels the sequence. Writing 16'h0123 again re-arms it.
- R8: Every completed refresh, allowed or not, reloads the counter and restarts the prescaler. A refresh wins over a tick in the same cycle.
- R9: A refresh outside every allowed quarter sets the sticky refresh-error flag.
- R10: With CFG[13]=0, irq_o is high exactly while either flag is set. With CFG[13]=1, irq_o stays low.
- R11: With CFG[13]=1, each error event gives a one-cycle rst_req_o pulse, in the cycle its flag becomes visible.
- R12: STATUS (address 2) reads the count in [15:0], underflow in [16] and refresh error in [17]. Writing 1 to bit 16 or bit 17 clears that flag alone. A new event in the same cycle wins over the clear.
- R13: A write to CFG (address 0) reloads the counter with the new period, restarts the prescaler and cancels an armed key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_i | input | 1 | Low-power indication |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Register address: 0 CFG, 1 KEY, 2 STATUS |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt level |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check the following:
- the count steps by one per tick, holds without a tick and lands on period-1 after any reload;
- the prescaler stays inside its division, and the count holds while frozen;
- both flags stay set until cleared;
- an armed key sequence disarms once it fires;
- the interrupt and reset-request outputs are consistent with the flags and the response mode.

Only the bench scenarios show the rest:
- the quarter arithmetic, including the 63/64 boundary with a non-contiguous mask;
- the exact prescaler ratios and period encodings;
- the cancellation rules of the key sequence;
- the pulse count of the reset request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;
  localparam int PRE_W = 11;
  localparam int AW    = 2;
  localparam int DW    = 32;

  localparam logic [AW-1:0] A_CFG  = 2'd0;
  localparam logic [AW-1:0] A_KEY  = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;

  localparam logic [15:0] KEY_ARM  = 16'h0123;
  localparam logic [15:0] KEY_FIRE = 16'h3210;

  typedef struct packed {
    logic       resp_rst;
    logic       lp_freeze;
    logic [3:0] win_mask;
    logic [3:0] div_code;
    logic [1:0] per_sel;
  } cfg_t;

  localparam cfg_t CFG_RST = '{resp_rst: 1'b0, lp_freeze: 1'b0, win_mask: 4'hF,
                               div_code: 4'h0, per_sel: 2'd0};

  function automatic logic [PRE_W-1:0] div_limit(input logic [3:0] code);
    case (code)
      4'd4:    return PRE_W'(15);
      4'd5:    return PRE_W'(31);
      4'd6:    return PRE_W'(63);
      4'd7:    return PRE_W'(127);
      4'd8:    return PRE_W'(255);
      4'd11:   return PRE_W'(2047);
      default: return '0;
    endcase
  endfunction

  function automatic int unsigned per_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 12;
      2'd2:    return 14;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] lim;

  assign lim    = W'(div_limit(code_i));
  assign tick_o = en_i & ~restart_i & (acc_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (restart_i) acc_q <= '0;
    else if (en_i)      acc_q <= tick_o ? '0 : acc_q + W'(1);
  end

  // R3: accumulator never passes the selected limit
  a_r3_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) acc_q <= lim);
  // R3: no back-to-back ticks unless dividing by one
  a_r3_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (lim != '0) |=> !tick_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         reload_i,
  input  logic [1:0]   per_sel_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o,
  output logic [1:0]   quarter_o
);
  localparam logic [W-1:0] RST_VAL = W'((1 << per_log2(2'd0)) - 1);

  logic [W-1:0] cnt_q, top_val, elapsed;
  int unsigned  lg;

  always_comb begin
    lg        = per_log2(per_sel_i);
    top_val   = W'((32'd1 << lg) - 32'd1);
    elapsed   = top_val - cnt_q;
    quarter_o = 2'(elapsed >> (lg - 2));
  end

  assign uf_o  = tick_i & ~reload_i & (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= RST_VAL;
    else if (reload_i || uf_o) cnt_q <= top_val;
    else if (tick_i)           cnt_q <= cnt_q - W'(1);
  end

  // R4: a plain tick steps down by one
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !reload_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));
  // R4: wrap lands on period-1
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |=> cnt_q == $past(top_val));
  // R8: any reload lands on period-1
  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(top_val));
  // R4: no tick, no reload, no change
  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !reload_i |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_refresh.sv
module wdt_refresh
  import wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   key_i,
  input  logic [3:0]    mask_i,
  input  logic [1:0]    quarter_i,
  output logic          fire_o,
  output logic          err_o
);
  logic armed_q;
  logic key_wr;

  assign key_wr = wr_i & (addr_i == A_KEY);
  assign fire_o = key_wr & (key_i == KEY_FIRE) & armed_q;
  assign err_o  = fire_o & ~mask_i[quarter_i];

  // any write other than the arm key drops the sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= key_wr & (key_i == KEY_ARM);
  end

  // R7: a fired sequence must be re-armed
  a_r7_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q);
endmodule

// File: rtl/win_wdt.sv
module win_wdt
  import wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lp_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  cfg_t             cfg_q, cfg_nxt, cfg_wr;
  logic             wr, cfg_we, stat_we;
  logic             tick, reload, cnt_en;
  logic             fire, ref_err_evt, uf_evt;
  logic             uf_q, ref_err_q, rst_req_q;
  logic [1:0]       quarter;
  logic [CNT_W-1:0] cnt;

  assign wr      = req_i & we_i;
  assign cfg_we  = wr & (addr_i == A_CFG);
  assign stat_we = wr & (addr_i == A_STAT);

  always_comb begin
    cfg_wr.per_sel   = wdata_i[1:0];
    cfg_wr.div_code  = wdata_i[7:4];
    cfg_wr.win_mask  = wdata_i[11:8];
    cfg_wr.lp_freeze = wdata_i[12];
    cfg_wr.resp_rst  = wdata_i[13];
    cfg_nxt          = cfg_we ? cfg_wr : cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_nxt;
  end

  assign cnt_en = ~(cfg_q.lp_freeze & lp_i);
  assign reload = cfg_we | fire;

  wdt_prescale u_pre (
    .clk_i, .rst_ni,
    .en_i      (cnt_en),
    .restart_i (reload),
    .code_i    (cfg_nxt.div_code),
    .tick_o    (tick)
  );

  wdt_counter u_cnt (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .reload_i  (reload),
    .per_sel_i (cfg_nxt.per_sel),
    .cnt_o     (cnt),
    .uf_o      (uf_evt),
    .quarter_o (quarter)
  );

  wdt_refresh u_ref (
    .clk_i, .rst_ni,
    .wr_i      (wr),
    .addr_i    (addr_i),
    .key_i     (wdata_i[15:0]),
    .mask_i    (cfg_q.win_mask),
    .quarter_i (quarter),
    .fire_o    (fire),
    .err_o     (ref_err_evt)
  );

  // sticky flags: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q      <= 1'b0;
      ref_err_q <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      uf_q      <= (uf_q & ~(stat_we & wdata_i[16])) | uf_evt;
      ref_err_q <= (ref_err_q & ~(stat_we & wdata_i[17])) | ref_err_evt;
      rst_req_q <= (uf_evt | ref_err_evt) & cfg_q.resp_rst;
    end
  end

  assign irq_o     = (uf_q | ref_err_q) & ~cfg_q.resp_rst;
  assign rst_req_o = rst_req_q;

  always_comb begin
    case (addr_i)
      A_CFG:   rdata_o = {18'b0, cfg_q.resp_rst, cfg_q.lp_freeze, cfg_q.win_mask,
                          cfg_q.div_code, 2'b0, cfg_q.per_sel};
      A_STAT:  rdata_o = {14'b0, ref_err_q, uf_q, cnt};
      default: rdata_o = '0;
    endcase
  end

  // R5: frozen counter holds
  a_r5_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lp_freeze && lp_i && !reload |=> $stable(cnt));
  // R9: refresh error stays until cleared
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_err_q && !(stat_we && wdata_i[17]) |=> ref_err_q);
  // R12: underflow stays until cleared
  a_r12_uf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q && !(stat_we && wdata_i[16]) |=> uf_q);
  // R11: a reset request is always backed by a flag
  a_r11_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (uf_q || ref_err_q));
  // R10: no interrupt in reset-response mode
  a_r10_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !cfg_q.resp_rst);
endmodule

// File: tb/win_wdt_tb_top.sv
module win_wdt_tb_top;
  import wdt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lp_i = 1'b1;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  always #2 clk = ~clk;  // 250 MHz

  win_wdt dut_i (
    .clk_i(clk), .rst_ni, .lp_i, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .rst_req_o
  );

  // scoreboard: 0 rdata, 1 irq_o, 2 reset pulses so far, 3 longest pulse
  int          sig_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];
  int          checks = 0, errors = 0, pulses = 0, run = 0, max_run = 0;
  bit          done = 0;

  always @(negedge clk) begin
    if (rst_req_o) begin
      pulses++; run++;
      if (run > max_run) max_run = run;
    end else run = 0;
    if (sig_q.size() > 0) begin
      int s; logic [31:0] e, m, act; string t;
      s = sig_q.pop_front(); e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
      case (s)
        0:       act = rdata_o & m;
        1:       act = {31'b0, irq_o};
        2:       act = 32'(pulses);
        default: act = 32'(max_run);
      endcase
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", t, act, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input logic [31:0] m,
                        input string t);
    @(posedge clk); #1;
    addr_i = a;
    sig_q.push_back(0); exp_q.push_back(e & m); msk_q.push_back(m); tag_q.push_back(t);
  endtask

  task automatic sig_chk(input int s, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    sig_q.push_back(s); exp_q.push_back(e); msk_q.push_back('1); tag_q.push_back(t);
  endtask

  task automatic lp_run(input int n);
    @(posedge clk); #1 lp_i = 1'b0;
    repeat (n) @(posedge clk);
    #1 lp_i = 1'b1;
  endtask

  task automatic refresh();
    wr(A_KEY, 32'h0000_0123);
    wr(A_KEY, 32'h0000_3210);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rd_chk(A_STAT, 32'h0000_00FF, '1, "R1 status in reset");
    rd_chk(A_CFG,  32'h0000_0F00, '1, "R1 config in reset");
    sig_chk(1, 0, "R1 irq low in reset");
    @(posedge clk); #1 rst_ni = 1'b1;
    rd_chk(A_CFG,  32'h0000_0F00, '1, "R1 config after reset");

    // no freeze: lp_i ignored, underflow after 256 cycles
    repeat (300) @(posedge clk);
    rd_chk(A_STAT, 32'h0001_0000, 32'h0003_0000, "R5 lp ignored without freeze");
    sig_chk(1, 1, "R10 irq with underflow");
    wr(A_STAT, 32'h0003_0000);
    rd_chk(A_STAT, 32'h0, 32'h0003_0000, "R12 clear both flags");
    sig_chk(1, 0, "R10 irq drops after clear");

    // freeze on, low power held: R13 reload, R5 hold
    wr(A_CFG, 32'h1F00);
    rd_chk(A_STAT, 32'h0000_00FF, '1, "R13 cfg write reloads");
    repeat (300) @(posedge clk);
    rd_chk(A_STAT, 32'h0000_00FF, '1, "R5 frozen in low power");
    lp_run(10);
    rd_chk(A_STAT, 32'h0000_00F5, '1, "R4 ten ticks");

    // period encodings
    wr(A_CFG, 32'h1F03); rd_chk(A_STAT, 32'hFFFF, '1, "R2 period code 3");
    wr(A_CFG, 32'h1F01); rd_chk(A_STAT, 32'h0FFF, '1, "R2 period code 1");
    wr(A_CFG, 32'h1F02); rd_chk(A_STAT, 32'h3FFF, '1, "R2 period code 2");
    lp_run(5);           rd_chk(A_STAT, 32'h3FFA, '1, "R2 R4 count in long period");

    // prescaler ratios
    wr(A_CFG, 32'h1F40); lp_run(80); rd_chk(A_STAT, 32'd250, '1, "R3 divide by 16");
    lp_run(15);          rd_chk(A_STAT, 32'd250, '1, "R3 no tick before 16th clock");
    lp_run(1);           rd_chk(A_STAT, 32'd249, '1, "R3 tick on 16th clock");
    wr(A_CFG, 32'h1FB0); lp_run(6144); rd_chk(A_STAT, 32'd252, '1, "R3 divide by 2048");
    wr(A_CFG, 32'h1F80); lp_run(512);  rd_chk(A_STAT, 32'd253, '1, "R3 divide by 256");
    wr(A_CFG, 32'h1F10); lp_run(10);   rd_chk(A_STAT, 32'd245, '1, "R3 unlisted code is /1");

    // underflow
    wr(A_CFG, 32'h1F00); lp_run(256);
    rd_chk(A_STAT, 32'h0001_00FF, '1, "R4 underflow flag and wrap");
    sig_chk(1, 1, "R10 irq level on underflow");
    wr(A_STAT, 32'h0001_0000);
    rd_chk(A_STAT, 32'h0000_00FF, '1, "R12 clear underflow");

    // window mask 5: quarters 0 and 2
    wr(A_CFG, 32'h1500);
    lp_run(10);  refresh(); rd_chk(A_STAT, 32'h0000_00FF, '1, "R6 R8 refresh in quarter 0");
    lp_run(63);  refresh(); rd_chk(A_STAT, 32'h0000_00FF, '1, "R6 elapsed 63 still quarter 0");
    lp_run(64);  refresh(); rd_chk(A_STAT, 32'h0002_00FF, '1, "R6 R9 elapsed 64 is quarter 1");
    lp_run(140); refresh(); rd_chk(A_STAT, 32'h0002_00FF, '1, "R6 R9 quarter 2 ok, flag sticky");
    sig_chk(1, 1, "R10 irq on refresh error");
    wr(A_STAT, 32'h0001_0000);
    rd_chk(A_STAT, 32'h0002_0000, 32'h0003_0000, "R12 clearing underflow leaves error");
    wr(A_STAT, 32'h0002_0000);
    rd_chk(A_STAT, 32'h0, 32'h0003_0000, "R12 clear error");
    lp_run(200); refresh(); rd_chk(A_STAT, 32'h0002_00FF, '1, "R6 quarter 3 rejected");
    wr(A_STAT, 32'h0002_0000);
    wr(A_CFG, 32'h1000); refresh();
    rd_chk(A_STAT, 32'h0002_00FF, '1, "R6 mask 0 always error");
    wr(A_STAT, 32'h0002_0000);

    // key sequence rules, all quarters allowed
    wr(A_CFG, 32'h1F00); lp_run(20);
    wr(A_KEY, 32'h3210);
    rd_chk(A_STAT, 32'd235, '1, "R7 fire key alone ignored");
    wr(A_KEY, 32'h0123); wr(A_STAT, 32'h0); wr(A_KEY, 32'h3210);
    rd_chk(A_STAT, 32'd235, '1, "R7 status write cancels");
    wr(A_KEY, 32'h0123); wr(A_KEY, 32'h5555); wr(A_KEY, 32'h3210);
    rd_chk(A_STAT, 32'd235, '1, "R7 wrong key cancels");
    wr(A_KEY, 32'h0123); wr(A_KEY, 32'h0123); wr(A_KEY, 32'h3210);
    rd_chk(A_STAT, 32'd255, '1, "R7 R8 re-armed refresh reloads");
    wr(A_KEY, 32'h0123); lp_run(20); wr(A_CFG, 32'h1F00); lp_run(5);
    wr(A_KEY, 32'h3210);
    rd_chk(A_STAT, 32'd250, '1, "R13 cfg write cancels armed key");

    // reset response
    sig_chk(2, 0, "R11 no pulse in interrupt mode");
    wr(A_CFG, 32'h3000); refresh();
    rd_chk(A_STAT, 32'h0002_00FF, '1, "R11 error flag in reset mode");
    sig_chk(2, 1, "R11 one pulse on refresh error");
    sig_chk(1, 0, "R10 irq masked in reset mode");
    wr(A_STAT, 32'h0003_0000);
    lp_run(256);
    rd_chk(A_STAT, 32'h0001_00FF, '1, "R11 underflow in reset mode");
    sig_chk(2, 2, "R11 one pulse on underflow");
    sig_chk(3, 1, "R11 pulse is one cycle wide");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule